// File: doc/BRIEF.md
# Interrupting General-Purpose I/O Port

This block is a register-mapped I/O port with up to 32 lines on an APB-style bus. Each line is an input or an output on its own. Software changes direction by writing masks to two write-only ports: one turns lines into inputs and the other turns them into outputs. Software changes output data by writing masks to a set port or a clear port, so two tasks that own different lines never need a read-modify-write. Pad inputs pass through a synchronizer chain before the state readback or the interrupt logic sees them.

Any line can raise an interrupt. In level mode a line raises it while its input is high, or while it is low. In edge mode it raises it on a rising edge, a falling edge or either edge. Each line has its own enable, and all lines feed one interrupt output. Level requests follow the input and cannot be cleared by software. Edge requests are held until software clears them through the clear port. The set and clear addresses also serve as read-only views: the set address returns the pin state and the clear address returns the pending lines. A write to the clear address therefore clears the output data bits and the held edge requests of the lines it names.

The bus has zero wait states and no error response. Only word-aligned addresses select a register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Writing a mask to word 0x00 makes the masked lines inputs, and writing a mask to word 0x04 makes them outputs. Zero bits leave their lines unchanged. Word 0x10 reads back the direction (1 = output), and `pin_oe` equals it.
- R2: A write to word 0x08 drives the lines with 1 bits high. A write to word 0x0C drives the lines with 1 bits low. Zero bits change nothing, and `pin_o` shows the output data.
- R3: A read of word 0x08 returns the output data for output lines and the synchronized pad value for input lines.
- R4: A pad change reaches the state readback and the level interrupt after exactly two clock edges.
- R5: In level mode (word 0x18 bit = 0) a line is pending while its synchronized input equals its polarity bit (word 0x1C, 1 = high). Writing its bit to word 0x0C does not clear it.
- R6: In edge mode (word 0x18 bit = 1) a line latches pending on a rising edge when its polarity bit is 1, and on a falling edge when it is 0. When its both-edges bit (word 0x20) is 1 it latches on either edge. The pending bit is seen three clock edges after the pad change.
- R7: A latched edge request stays pending until a 1 is written to its bit at word 0x0C. Zero bits in that write leave it pending.
- R8: An edge detected in the same cycle as a clear write to the same line wins, so the line stays pending.
- R9: A line whose enable bit (word 0x14) is 0 never shows pending and never raises `irq_o`.
- R10: `irq_o` is high exactly when any line reads pending at word 0x0C.
- R11: After reset all lines are inputs and output data is zero. All enables, mode, polarity and both-edges bits are zero, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and system clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data |
| pin_i | input | N_LINES (32) | Pad input values |
| pin_o | output | N_LINES (32) | Output data to the pads |
| pin_oe | output | N_LINES (32) | Output enable per line |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default values: 32 lines, an 8-bit byte address, a 32-bit data bus and a two-stage synchronizer. With 32 lines the top line and several separate lines can be exercised at once, so masks with gaps can confirm that zero bits leave their lines alone. With two stages the exact cycle counts are fixed and can be checked: two edges before a pad change is seen, three before an edge request latches. That same fixed count lets the bench time an edge to land in the same cycle as a clear write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // word indices (byte address / 4)
   localparam int WI_MK_IN  = 0;
   localparam int WI_MK_OUT = 1;
   localparam int WI_SET    = 2;   // read: pin state
   localparam int WI_CLR    = 3;   // read: pending
   localparam int WI_DIR    = 4;
   localparam int WI_ENA    = 5;
   localparam int WI_MODE   = 6;   // 1 = edge
   localparam int WI_POL    = 7;   // 1 = high / rising
   localparam int WI_BOTH   = 8;   // 1 = either edge

   typedef struct packed {
      logic mk_in;
      logic mk_out;
      logic set;
      logic clr;
      logic ena;
      logic mode;
      logic pol;
      logic both;
   } wr_hit_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int N      = 32,
   parameter int AW     = 8,
   parameter int DW     = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          psel,
   input  logic          penable,
   input  logic          pwrite,
   input  logic [AW-1:0] paddr,
   input  logic [DW-1:0] pwdata,
   output logic [DW-1:0] prdata,
   input  logic [N-1:0]  sync_i,
   input  logic [N-1:0]  pend_i,
   output logic [N-1:0]  dir_o,
   output logic [N-1:0]  dout_o,
   output logic [N-1:0]  ena_o,
   output logic [N-1:0]  mode_o,
   output logic [N-1:0]  pol_o,
   output logic [N-1:0]  both_o,
   output logic [N-1:0]  clr_o
);
   localparam int IDX_W = AW - 2;

   generate
      if (AW < 6) begin : g_aw_bad
         $error("gpio_irq_regs: address too narrow for the map");
      end
      if (N > DW) begin : g_n_bad
         $error("gpio_irq_regs: more lines than data bits");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             aligned, wr_acc;
   wr_hit_t          hit;
   logic [N-1:0]     wmask;

   assign idx     = paddr[AW-1:2];
   assign aligned = (paddr[1:0] == 2'b00);
   assign wr_acc  = psel & penable & pwrite & aligned;
   assign wmask   = pwdata[N-1:0];

   always_comb begin
      hit        = '0;
      hit.mk_in  = wr_acc && (idx == IDX_W'(WI_MK_IN));
      hit.mk_out = wr_acc && (idx == IDX_W'(WI_MK_OUT));
      hit.set    = wr_acc && (idx == IDX_W'(WI_SET));
      hit.clr    = wr_acc && (idx == IDX_W'(WI_CLR));
      hit.ena    = wr_acc && (idx == IDX_W'(WI_ENA));
      hit.mode   = wr_acc && (idx == IDX_W'(WI_MODE));
      hit.pol    = wr_acc && (idx == IDX_W'(WI_POL));
      hit.both   = wr_acc && (idx == IDX_W'(WI_BOTH));
   end

   logic [N-1:0] dir_q, dout_q, ena_q, mode_q, pol_q, both_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         dout_q <= '0;
         ena_q  <= '0;
         mode_q <= '0;
         pol_q  <= '0;
         both_q <= '0;
      end else begin
         if (hit.mk_in)  dir_q  <= dir_q & ~wmask;
         if (hit.mk_out) dir_q  <= dir_q | wmask;
         if (hit.set)    dout_q <= dout_q | wmask;
         if (hit.clr)    dout_q <= dout_q & ~wmask;
         if (hit.ena)    ena_q  <= wmask;
         if (hit.mode)   mode_q <= wmask;
         if (hit.pol)    pol_q  <= wmask;
         if (hit.both)   both_q <= wmask;
      end
   end

   assign dir_o  = dir_q;
   assign dout_o = dout_q;
   assign ena_o  = ena_q;
   assign mode_o = mode_q;
   assign pol_o  = pol_q;
   assign both_o = both_q;
   assign clr_o  = hit.clr ? wmask : '0;

   logic [N-1:0] rd_n;
   always_comb begin
      rd_n = '0;
      if (aligned) begin
         if      (idx == IDX_W'(WI_SET))  rd_n = (dir_q & dout_q) | (~dir_q & sync_i);
         else if (idx == IDX_W'(WI_CLR))  rd_n = pend_i;
         else if (idx == IDX_W'(WI_DIR))  rd_n = dir_q;
         else if (idx == IDX_W'(WI_ENA))  rd_n = ena_q;
         else if (idx == IDX_W'(WI_MODE)) rd_n = mode_q;
         else if (idx == IDX_W'(WI_POL))  rd_n = pol_q;
         else if (idx == IDX_W'(WI_BOTH)) rd_n = both_q;
      end
   end
   assign prdata = DW'(rd_n);

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      hit.set |=> ((dout_q & $past(wmask)) == $past(wmask)));   // R2
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      hit.clr |=> ((dout_q & $past(wmask)) == '0));   // R2
   AST_MKIN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      hit.mk_in |=> ((dir_q & $past(wmask)) == '0));   // R1
   AST_MKOUT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      hit.mk_out |=> ((dir_q & $past(wmask)) == $past(wmask)));   // R1
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
   input  logic clk,
   input  logic rst_n,
   input  logic s_i,
   input  logic en_i,
   input  logic edge_i,
   input  logic pol_i,
   input  logic both_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q, latch_q, rise, fall, edge_hit;

   assign rise     = s_i & ~prev_q;
   assign fall     = ~s_i & prev_q;
   assign edge_hit = both_i ? (rise | fall) : (pol_i ? rise : fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= s_i;
         latch_q <= en_i & edge_i & (edge_hit | (latch_q & ~clr_i));
      end
   end

   assign pend_o = en_i & (edge_i ? latch_q : (s_i == pol_i));

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && en_i && edge_i && !clr_i) |=> latch_q);   // R7
   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && edge_i && edge_hit && clr_i) |=> latch_q);   // R8
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
   parameter int N_LINES     = 32,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic               pclk,
   input  logic               presetn,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [ADDR_W-1:0]  paddr,
   input  logic [DATA_W-1:0]  pwdata,
   output logic [DATA_W-1:0]  prdata,
   input  logic [N_LINES-1:0] pin_i,
   output logic [N_LINES-1:0] pin_o,
   output logic [N_LINES-1:0] pin_oe,
   output logic               irq_o
);
   logic [N_LINES-1:0] sync_v, pend_v, dir_v, dout_v, ena_v, mode_v, pol_v, both_v, clr_v;

   gpio_irq_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(pclk), .rst_n(presetn), .d_i(pin_i), .q_o(sync_v)
   );

   gpio_irq_regs #(.N(N_LINES), .AW(ADDR_W), .DW(DATA_W)) u_regs (
      .clk(pclk), .rst_n(presetn),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .sync_i(sync_v), .pend_i(pend_v),
      .dir_o(dir_v), .dout_o(dout_v), .ena_o(ena_v),
      .mode_o(mode_v), .pol_o(pol_v), .both_o(both_v), .clr_o(clr_v)
   );

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         gpio_irq_line u_line (
            .clk(pclk), .rst_n(presetn),
            .s_i(sync_v[i]), .en_i(ena_v[i]), .edge_i(mode_v[i]),
            .pol_i(pol_v[i]), .both_i(both_v[i]), .clr_i(clr_v[i]),
            .pend_o(pend_v[i])
         );
      end
   endgenerate

   assign pin_o  = dout_v;
   assign pin_oe = dir_v;
   assign irq_o  = |pend_v;

   AST_DIS_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
      ((pend_v & ~ena_v) == '0));   // R9
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
   localparam time CLK_P = 10ns;
   localparam int  N = 32;

   logic        pclk = 1'b0, presetn = 1'b0;
   logic        psel = 0, penable = 0, pwrite = 0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0, prdata;
   logic [N-1:0] pin_i = '0, pin_o, pin_oe;
   logic        irq_o;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) pclk = ~pclk;

   gpio_irq_ctrl u0 (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge pclk);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge pclk);
      psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge pclk);
      penable = 1;
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge pclk);
      penable = 1;
      #1 d = prdata;
      @(negedge pclk);
      psel = 0; penable = 0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h10, v); chk("R11 dir", v, 0);
      rd(8'h0C, v); chk("R11 pending", v, 0);
      rd(8'h14, v); chk("R11 enable", v, 0);
      rd(8'h18, v); chk("R11 mode", v, 0);
      rd(8'h1C, v); chk("R11 polarity", v, 0);
      rd(8'h20, v); chk("R11 both", v, 0);
      chk("R11 pin_o", pin_o, 0);
      chk("R11 irq", {31'b0, irq_o}, 0);
   endtask

   task automatic t_dir();
      logic [31:0] v;
      wr(8'h04, 32'h0000_00F0);
      rd(8'h10, v); chk("R1 make-output", v, 32'hF0);
      wr(8'h04, 32'h8000_000F);
      rd(8'h10, v); chk("R1 zero bits keep", v, 32'h8000_00FF);
      wr(8'h00, 32'h8000_0030);
      rd(8'h10, v); chk("R1 make-input", v, 32'hCF);
      chk("R1 pin_oe", pin_oe, 32'hCF);
   endtask

   task automatic t_out();
      logic [31:0] v;
      wr(8'h08, 32'h81);
      wr(8'h08, 32'h02);
      chk("R2 set", pin_o, 32'h83);
      wr(8'h0C, 32'h01);
      chk("R2 clear", pin_o, 32'h82);
      rd(8'h08, v); chk("R3 state outputs", v, 32'h82);
      @(negedge pclk) pin_i = 32'h0000_0105;   // bit0 output: ignored in state
      tick(3);
      rd(8'h08, v); chk("R3 state mixed", v, 32'h182);
      pin_i = '0;
      tick(3);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(8'h1C, 32'h200);
      wr(8'h14, 32'h200);
      chk("R5 idle", {31'b0, irq_o}, 0);
      @(negedge pclk) pin_i[9] = 1'b1;
      tick(1); chk("R4 one edge", {31'b0, irq_o}, 0);
      tick(1); chk("R4 two edges", {31'b0, irq_o}, 1);
      rd(8'h08, v); chk("R4 state", v & 32'h200, 32'h200);
      wr(8'h0C, 32'h200);
      rd(8'h0C, v); chk("R5 no clear", v, 32'h200);
      chk("R10 irq", {31'b0, irq_o}, 1);
      @(negedge pclk) pin_i[9] = 1'b0;
      tick(2); chk("R5 cond gone", {31'b0, irq_o}, 0);
      wr(8'h1C, 32'h0);
      rd(8'h0C, v); chk("R5 low level", v, 32'h200);
      wr(8'h14, 32'h0);
      chk("R9 disabled level", {31'b0, irq_o}, 0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      wr(8'h18, 32'h0000_F000);
      wr(8'h1C, 32'h0000_1000);
      wr(8'h20, 32'h0000_4000);
      wr(8'h14, 32'h0000_7000);
      // rising on line 12
      @(negedge pclk) pin_i[12] = 1'b1;
      tick(2); chk("R6 not yet", {31'b0, irq_o}, 0);
      tick(1); chk("R6 rise latched", {31'b0, irq_o}, 1);
      @(negedge pclk) pin_i[12] = 1'b0;
      tick(4);
      wr(8'h0C, 32'h0000_0001);
      rd(8'h0C, v); chk("R7 sticky", v, 32'h1000);
      wr(8'h0C, 32'h0000_1000);
      rd(8'h0C, v); chk("R7 cleared", v, 0);
      // falling on line 13
      @(negedge pclk) pin_i[13] = 1'b1;
      tick(4);
      rd(8'h0C, v); chk("R6 rise ignored", v, 0);
      @(negedge pclk) pin_i[13] = 1'b0;
      tick(4);
      rd(8'h0C, v); chk("R6 fall", v, 32'h2000);
      wr(8'h0C, 32'h2000);
      // both on line 14
      @(negedge pclk) pin_i[14] = 1'b1;
      tick(4);
      rd(8'h0C, v); chk("R6 both rise", v, 32'h4000);
      wr(8'h0C, 32'h4000);
      @(negedge pclk) pin_i[14] = 1'b0;
      tick(4);
      rd(8'h0C, v); chk("R6 both fall", v, 32'h4000);
      wr(8'h0C, 32'h4000);
      // disabled edge line 15
      @(negedge pclk) pin_i[15] = 1'b1;
      tick(4);
      @(negedge pclk) pin_i[15] = 1'b0;
      tick(4);
      rd(8'h0C, v); chk("R9 disabled edge", v, 0);
      chk("R10 quiet", {31'b0, irq_o}, 0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      pin_i[12] = 1'b1;            // just after a negedge
      @(negedge pclk);
      psel = 1; pwrite = 1; paddr = 8'h0C; pwdata = 32'h1000; penable = 0;
      @(negedge pclk);
      penable = 1;
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
      rd(8'h0C, v); chk("R8 edge wins", v, 32'h1000);
      wr(8'h0C, 32'h1000);
      rd(8'h0C, v); chk("R8 later clear", v, 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(3);
      presetn = 1'b1;
      tick(2);
      t_reset();
      t_dir();
      t_out();
      t_level();
      t_edge();
      @(negedge pclk);
      t_race();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule